// File: doc/BRIEF.md
# Command and Result Ring Node

This block sits on a one-way ring of 8-bit flits. A single controller starts every round by sending four packets around the ring. Each packet is a header flit followed by three payload flits. A packet is either a command for one worker node, or an empty slot. Any worker node may load an empty slot with a result for the controller. The node does not store packets hop by hop. Each flit passes through one output register, so the node adds exactly one cycle of delay to the ring.

When the node sees a command header that carries its own address, it takes the three payload bytes and hands them to the local module as one 24-bit word with a one-cycle strobe. It then rewrites that packet as an empty slot for the nodes further down the ring. The local module pushes results into a four-entry buffer through a valid/ready handshake. The node fills at most one empty slot per round, taking the oldest buffered result. The node never creates a packet of its own, so return traffic can only travel in empty slots that pass by.

Header encoding:
- Bits [7:6] give the packet type: 00 empty, 01 command, 10 filled result, 11 illegal.
- Bits [5:0] give the node address.

Top module: `ring_node`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `ring_out_valid` is 0, `ring_out_flit` is 0, `cmd_valid` is 0, `res_full` is 0 and `res_ready` is 1.
- R2: After reset, the node ignores valid flits whose bits [7:6] are 11 and drives idle zero flits for them. The first valid flit with any other type locks the node and is taken as the header of packet 0 of a round.
- R3: Once locked, each valid input flit appears at the output one cycle later, unchanged. This covers commands to other addresses, filled results, and empty slots the node does not fill. A cycle with `ring_in_valid` low gives `ring_out_valid` 0 and a zero flit one cycle later. Gap cycles do not advance the flit position.
- R4: A command header (type 01) whose bits [5:0] equal NODE_ID is consumed. In the cycle the fourth flit's output appears, `cmd_valid` is high for exactly one cycle. In that cycle `cmd_data` holds the payload with the first payload flit in bits [23:16] and the last in bits [7:0].
- R5: A consumed command leaves the node as header 0x00 followed by three zero flits. This node does not fill the slot it has just emptied.
- R6: A valid empty header (type 00), arriving while the buffer holds a result and no slot has been filled this round, is sent out with the buffered result:
  - The header becomes {2'b10, NODE_ID}.
  - The payload flits carry the oldest result, bits [23:16] first.
  - That result is then removed from the buffer.
- R7: At most one empty slot is filled per round of four packets (sixteen accepted flits). Later empty slots in the same round are forwarded unchanged, and filling resumes in the next round.
- R8: The result buffer holds four entries in FIFO order. `res_ready` is the inverse of `res_full`, and `res_full` is 1 exactly when four results are held. A result offered while full is not stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_in_valid | input | 1 | Flit from the upstream neighbour is valid |
| ring_in_flit | input | 8 | Flit from the upstream neighbour |
| ring_out_valid | output | 1 | Flit to the downstream neighbour is valid |
| ring_out_flit | output | 8 | Flit to the downstream neighbour, zero when idle |
| cmd_valid | output | 1 | One-cycle strobe for a command received by this node |
| cmd_data | output | 24 | Payload of the received command |
| res_valid | input | 1 | Local module offers a result |
| res_data | input | 24 | Result word |
| res_ready | output | 1 | Result buffer can accept a word |
| res_full | output | 1 | Result buffer holds four words |

## Verification
The assertions check these properties on every cycle:
- Idle output flits are zero.
- A locked node turns each valid input into a valid output one cycle later.
- Lock is never lost once gained.
- The command strobe lasts a single cycle.
- The result buffer is never pushed when full or popped when empty.

The bench's scenarios are the only way to show three things. First, that payload bytes keep their order and arrive in the right register. Second, that a consumed slot goes out blank and is not refilled by this node. Third, that only the first eligible empty slot of each round is filled and results come out in FIFO order. A behavioural model in the bench predicts every output and is compared on each clock.

// File: rtl/ring_node_pkg.sv
package ring_node_pkg;
  typedef enum logic [1:0] {
    PK_EMPTY = 2'b00,
    PK_CMD   = 2'b01,
    PK_RES   = 2'b10,
    PK_BAD   = 2'b11
  } pkt_kind_t;

  typedef enum logic [1:0] {
    SLOT_PASS = 2'b00,
    SLOT_TAKE = 2'b01,
    SLOT_LOAD = 2'b10
  } slot_mode_t;
endpackage

// File: rtl/ring_node_track.sv
module ring_node_track #(
  parameter int FLITS_PER_PKT  = 4,
  parameter int PKTS_PER_ROUND = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic hdr_ok,
  output logic accept,
  output logic locked,
  output logic is_hdr,
  output logic is_last,
  output logic round_end
);
  localparam int FP_W = (FLITS_PER_PKT > 1) ? $clog2(FLITS_PER_PKT) : 1;
  localparam int PP_W = (PKTS_PER_ROUND > 1) ? $clog2(PKTS_PER_ROUND) : 1;
  localparam logic [FP_W-1:0] FP_LAST = FP_W'(FLITS_PER_PKT - 1);
  localparam logic [PP_W-1:0] PP_LAST = PP_W'(PKTS_PER_ROUND - 1);

  logic [FP_W-1:0] flit_pos;
  logic [PP_W-1:0] pkt_pos;

  assign accept    = in_valid && (locked || hdr_ok);
  assign is_hdr    = (flit_pos == '0);
  assign is_last   = (flit_pos == FP_LAST);
  assign round_end = is_last && (pkt_pos == PP_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      locked   <= 1'b0;
      flit_pos <= '0;
      pkt_pos  <= '0;
    end else if (accept) begin
      locked <= 1'b1;
      if (is_last) begin
        flit_pos <= '0;
        pkt_pos  <= (pkt_pos == PP_LAST) ? '0 : pkt_pos + 1'b1;
      end else begin
        flit_pos <= flit_pos + 1'b1;
      end
    end
  end

  // R2: once the first header is seen, the node stays aligned
  assert_lock_holds_R2: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked);
endmodule

// File: rtl/ring_node_rbuf.sv
module ring_node_rbuf #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  assign full  = (count == CNT_MAX);
  assign empty = (count == '0);
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/ring_node.sv
module ring_node
  import ring_node_pkg::*;
#(
  parameter int FLIT_W         = 8,
  parameter int PAYLOAD_FLITS  = 3,
  parameter int PKTS_PER_ROUND = 4,
  parameter int RBUF_DEPTH     = 4,
  parameter int NODE_ID        = 5
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            ring_in_valid,
  input  logic [FLIT_W-1:0]               ring_in_flit,
  output logic                            ring_out_valid,
  output logic [FLIT_W-1:0]               ring_out_flit,
  output logic                            cmd_valid,
  output logic [FLIT_W*PAYLOAD_FLITS-1:0] cmd_data,
  input  logic                            res_valid,
  input  logic [FLIT_W*PAYLOAD_FLITS-1:0] res_data,
  output logic                            res_ready,
  output logic                            res_full
);
  localparam int ADDR_W = FLIT_W - 2;
  localparam int PAY_W  = FLIT_W * PAYLOAD_FLITS;
  localparam int TB_W   = PAY_W - FLIT_W;
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(NODE_ID);

  pkt_kind_t        kind;
  logic [ADDR_W-1:0] addr;
  logic accept, locked, is_hdr, is_last, round_end;
  logic rb_full, rb_empty, rb_push, fill_now, take_now;
  logic [PAY_W-1:0] rb_dout;

  slot_mode_t       mode;
  logic             filled_round;
  logic [TB_W-1:0]  take_buf;
  logic [PAY_W-1:0] load_sh;

  assign kind = pkt_kind_t'(ring_in_flit[FLIT_W-1 -: 2]);
  assign addr = ring_in_flit[ADDR_W-1:0];

  ring_node_track #(
    .FLITS_PER_PKT (PAYLOAD_FLITS + 1),
    .PKTS_PER_ROUND(PKTS_PER_ROUND)
  ) i_track (
    .clk      (clk),
    .rst      (rst),
    .in_valid (ring_in_valid),
    .hdr_ok   (kind != PK_BAD),
    .accept   (accept),
    .locked   (locked),
    .is_hdr   (is_hdr),
    .is_last  (is_last),
    .round_end(round_end)
  );

  assign take_now = accept && is_hdr && (kind == PK_CMD) && (addr == MY_ADDR);
  assign fill_now = accept && is_hdr && (kind == PK_EMPTY) && !filled_round && !rb_empty;
  assign rb_push  = res_valid && !rb_full;

  ring_node_rbuf #(
    .DEPTH(RBUF_DEPTH),
    .WIDTH(PAY_W)
  ) i_rbuf (
    .clk  (clk),
    .rst  (rst),
    .push (rb_push),
    .din  (res_data),
    .pop  (fill_now),
    .dout (rb_dout),
    .full (rb_full),
    .empty(rb_empty)
  );

  assign res_ready = !rb_full;
  assign res_full  = rb_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      ring_out_valid <= 1'b0;
      ring_out_flit  <= '0;
      cmd_valid      <= 1'b0;
      cmd_data       <= '0;
      mode           <= SLOT_PASS;
      filled_round   <= 1'b0;
      take_buf       <= '0;
      load_sh        <= '0;
    end else begin
      cmd_valid <= 1'b0;
      if (accept) begin
        ring_out_valid <= 1'b1;
        if (is_hdr) begin
          if (take_now) begin
            mode          <= SLOT_TAKE;
            ring_out_flit <= '0;
          end else if (fill_now) begin
            mode          <= SLOT_LOAD;
            filled_round  <= 1'b1;
            load_sh       <= rb_dout;
            ring_out_flit <= {PK_RES, MY_ADDR};
          end else begin
            mode          <= SLOT_PASS;
            ring_out_flit <= ring_in_flit;
          end
        end else begin
          case (mode)
            SLOT_TAKE: begin
              ring_out_flit <= '0;
              take_buf      <= (take_buf << FLIT_W) | TB_W'(ring_in_flit);
              if (is_last) begin
                cmd_valid <= 1'b1;
                cmd_data  <= {take_buf, ring_in_flit};
              end
            end
            SLOT_LOAD: begin
              ring_out_flit <= load_sh[PAY_W-1 -: FLIT_W];
              load_sh       <= load_sh << FLIT_W;
            end
            default: ring_out_flit <= ring_in_flit;
          endcase
        end
        if (round_end) filled_round <= 1'b0;
      end else begin
        ring_out_valid <= 1'b0;
        ring_out_flit  <= '0;
      end
    end
  end

  assert_idle_zero_R3: assert property (@(posedge clk) disable iff (rst)
    !ring_out_valid |-> (ring_out_flit == '0));
  assert_one_cycle_latency_R3: assert property (@(posedge clk) disable iff (rst)
    (locked && ring_in_valid) |=> ring_out_valid);
  assert_cmd_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);
endmodule

// File: tb/test_ring_node.sv
module test_ring_node;
  localparam int ID = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ring_in_valid = 1'b0;
  logic [7:0] ring_in_flit = '0;
  logic ring_out_valid, cmd_valid, res_ready, res_full;
  logic [7:0] ring_out_flit;
  logic [23:0] cmd_data;
  logic res_valid = 1'b0;
  logic [23:0] res_data = '0;

  int errors = 0;
  int checks = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  ring_node #(.NODE_ID(ID)) i_ring_node (
    .clk(clk), .rst(rst),
    .ring_in_valid(ring_in_valid), .ring_in_flit(ring_in_flit),
    .ring_out_valid(ring_out_valid), .ring_out_flit(ring_out_flit),
    .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .res_valid(res_valid), .res_data(res_data),
    .res_ready(res_ready), .res_full(res_full)
  );

  // behavioural reference model
  logic [23:0] q[$];
  bit m_locked, m_filled;
  int m_pos, m_mode;
  logic [23:0] m_buf, m_cur;
  logic e_valid, e_cmdv;
  logic [7:0] e_flit;
  logic [23:0] e_cmd;

  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      m_locked = 0; m_filled = 0; m_pos = 0; m_mode = 0;
      e_valid = 0; e_flit = 0; e_cmdv = 0; e_cmd = 0; m_buf = 0; m_cur = 0;
    end else begin
      bit ready_pre;
      ready_pre = (q.size() < 4);
      e_cmdv = 0;
      if (ring_in_valid && (m_locked || ring_in_flit[7:6] != 2'b11)) begin
        int k;
        k = m_pos % 4;
        if (k == 0) begin
          if (ring_in_flit[7:6] == 2'b01 && ring_in_flit[5:0] == ID) begin
            m_mode = 1; e_flit = 8'h00; m_buf = 0;
          end else if (ring_in_flit[7:6] == 2'b00 && !m_filled && q.size() > 0) begin
            m_mode = 2; m_filled = 1; m_cur = q.pop_front();
            e_flit = 8'h80 | 8'(ID);
          end else begin
            m_mode = 0; e_flit = ring_in_flit;
          end
        end else begin
          if (m_mode == 1) begin
            m_buf = m_buf | (24'(ring_in_flit) << (8 * (3 - k)));
            e_flit = 8'h00;
            if (k == 3) begin e_cmdv = 1; e_cmd = m_buf; end
          end else if (m_mode == 2) begin
            e_flit = 8'((m_cur >> (8 * (3 - k))) & 24'hff);
          end else begin
            e_flit = ring_in_flit;
          end
        end
        e_valid = 1; m_locked = 1;
        m_pos = (m_pos + 1) % 16;
        if (m_pos == 0) m_filled = 0;
      end else begin
        e_valid = 0; e_flit = 0;
      end
      if (res_valid && ready_pre) q.push_back(res_data);
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      check(ring_out_valid === e_valid, cur_req, "out_valid", 32'(ring_out_valid), 32'(e_valid));
      check(ring_out_flit === e_flit, cur_req, "out_flit", 32'(ring_out_flit), 32'(e_flit));
      check(cmd_valid === e_cmdv, cur_req, "cmd_valid", 32'(cmd_valid), 32'(e_cmdv));
      if (e_cmdv) check(cmd_data === e_cmd, cur_req, "cmd_data", 32'(cmd_data), 32'(e_cmd));
      check(res_full === (q.size() == 4), cur_req, "res_full", 32'(res_full), 32'(q.size() == 4));
      check(res_ready === (q.size() < 4), cur_req, "res_ready", 32'(res_ready), 32'(q.size() < 4));
    end
  end

  task automatic flit(input logic v, input logic [7:0] f);
    @(negedge clk);
    ring_in_valid = v; ring_in_flit = f;
  endtask

  task automatic pkt(input logic [7:0] h, input logic [7:0] a, input logic [7:0] b,
                     input logic [7:0] c);
    flit(1, h); flit(1, a); flit(1, b); flit(1, c);
  endtask

  task automatic push(input logic [23:0] d);
    @(negedge clk);
    res_valid = 1; res_data = d;
    @(negedge clk);
    res_valid = 0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(ring_out_valid === 0, "R1", "out_valid", 32'(ring_out_valid), 0);
    check(ring_out_flit === 0, "R1", "out_flit", 32'(ring_out_flit), 0);
    check(cmd_valid === 0, "R1", "cmd_valid", 32'(cmd_valid), 0);
    check(res_ready === 1 && res_full === 0, "R1", "ready/full",
          32'({res_ready, res_full}), 32'h2);
    rst = 0;
    @(negedge clk);
    check(ring_out_valid === 0 && ring_out_flit === 0, "R1", "post-reset out",
          32'({ring_out_valid, ring_out_flit}), 0);
    // R2 illegal flits before lock are ignored
    cur_req = "R2";
    flit(1, 8'hC5); flit(1, 8'hFF); flit(0, 8'h00);
    // R3 forward foreign command, result, with a gap
    cur_req = "R3";
    pkt(8'h43, 8'h11, 8'h22, 8'h33);
    flit(0, 8'h00);
    pkt(8'h82, 8'h9A, 8'hBC, 8'hDE);
    // R4/R5 consume command to this node
    cur_req = "R4";
    flit(1, 8'h45); flit(1, 8'hA1); flit(0, 8'h00); flit(1, 8'hB2); flit(1, 8'hC3);
    // R6 empty with nothing buffered is forwarded
    cur_req = "R6";
    pkt(8'h00, 8'h00, 8'h00, 8'h00);
    flit(0, 8'h00);
    // R8 fill buffer to full; fifth offer refused
    cur_req = "R8";
    push(24'h111111); push(24'h222222); push(24'h333333); push(24'h444444);
    check(res_full === 1, "R8", "full after four", 32'(res_full), 1);
    push(24'h555555);
    check(res_ready === 0, "R8", "ready when full", 32'(res_ready), 0);
    // R6/R7 round with several empties: only the first is filled
    cur_req = "R7";
    pkt(8'h00, 8'h00, 8'h00, 8'h00);
    pkt(8'h00, 8'h00, 8'h00, 8'h00);
    pkt(8'h45, 8'h01, 8'h02, 8'h03);
    pkt(8'h00, 8'h00, 8'h00, 8'h00);
    // R5 consumed slot goes out blank, next empty filled in new round
    cur_req = "R5";
    pkt(8'h45, 8'hDE, 8'hAD, 8'hBE);
    pkt(8'h00, 8'h00, 8'h00, 8'h00);
    pkt(8'h00, 8'h00, 8'h00, 8'h00);
    pkt(8'h41, 8'h77, 8'h66, 8'h55);
    // R6 FIFO order across further rounds
    cur_req = "R6";
    for (int r = 0; r < 2; r++) begin
      pkt(8'h00, 8'h00, 8'h00, 8'h00);
      pkt(8'h82, 8'h01, 8'h02, 8'h03);
      pkt(8'h00, 8'h00, 8'h00, 8'h00);
      pkt(8'h46, 8'h0A, 8'h0B, 8'h0C);
    end
    check(res_full === 0, "R8", "drained", 32'(res_full), 0);
    flit(0, 8'h00); flit(0, 8'h00);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule